// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits between the bus-capture logic of a parallel NOR-style flash and its program/erase engine. Each latched bus write arrives as a one-cycle strobe with an address and a byte. The decoder works out which multi-write command these writes form. It tracks how far an unlock prefix has progressed and keeps a mode register (read array, identifier read or unlock-bypass). When a command completes it emits a one-cycle start pulse for a program or a chip erase, or a one-cycle reset request.

The read data path uses the `readSel` output to choose what a bus read returns. A program pulse carries the target address and byte taken from the final write of the command. Bad sequences drop the decoder back to read-array mode. While the downstream engine reports busy, every write is ignored. In unlock-bypass mode a program takes only two writes, and the only other command accepted there is a two-write exit.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `readSel` is 0 (read array; encoding 0 = array, 1 = identifier, 2 = bypass) and `progStart`, `eraseStart` and `resetReq` are low.
- R2: The writes AAh at 555h, 55h at 2AAh, then 90h at 555h set `readSel` to 1 one cycle after the third write. The value holds while no further write arrives.
- R3: The writes AAh at 555h, 55h at 2AAh, A0h at 555h, then any address/byte give a one-cycle `progStart` one cycle after the fourth write. `progAddr` and `progData` equal that write's address and byte, and `readSel` becomes 0.
- R4: Only address bits 10:0 take part in command matching; any value in the higher address bits is accepted.
- R5: Outside bypass mode, a write of F0h to any address (other than the data write of a program) gives a one-cycle `resetReq` and sets `readSel` to 0.
- R6: A write that does not continue a valid sequence returns the decoder to idle with `readSel` 0 and produces no pulse.
- R7: Chip erase is unlock prefix, 80h at 555h, unlock prefix, 10h at 555h. A one-cycle `eraseStart` follows only the sixth write, and `readSel` becomes 0.
- R8: Unlock prefix then 20h at 555h sets `readSel` to 2. In that mode, A0h at any address followed by an address/byte write gives `progStart` with that address and byte, and `readSel` stays 2.
- R9: In bypass mode every other write (including F0h when `opError` is low and 90h followed by a non-00h byte) produces no pulse and leaves `readSel` at 2.
- R10: In bypass mode, 90h at any address followed by 00h at any address sets `readSel` to 0.
- R11: While `busy` is high, writes change neither `readSel` nor the sequence progress, and produce no pulse.
- R12: In bypass mode, F0h at any address while `opError` is high gives a one-cycle `resetReq`, and `readSel` stays 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | One-cycle strobe for a latched bus write |
| wrAddr | input | ADDR_W | Address of the bus write |
| wrData | input | 8 | Byte of the bus write |
| busy | input | 1 | Program or erase in progress |
| opError | input | 1 | Engine reports a failed operation |
| readSel | output | 2 | Read source: 0 array, 1 identifier, 2 bypass |
| progStart | output | 1 | One-cycle program start |
| eraseStart | output | 1 | One-cycle chip erase start |
| resetReq | output | 1 | One-cycle reset request |
| progAddr | output | ADDR_W | Program target address |
| progData | output | 8 | Program target byte |

## Verification
The assertions assume that `wrValid` is a single-cycle strobe per bus write, so two commands never complete in adjacent cycles. They also assume that `busy` and `opError` change only between writes. The stimulus issues each write for exactly one cycle and toggles `busy` and `opError` only while `wrValid` is low. Because of this, every pulse can be traced to one write, and the `$past` relations between a pulse and the preceding write hold.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int CMP_W  = 11;
  localparam int BYTE_W = 8;

  localparam logic [CMP_W-1:0] KEY_ADDR_A = 11'h555;
  localparam logic [CMP_W-1:0] KEY_ADDR_B = 11'h2AA;

  localparam logic [BYTE_W-1:0] CODE_KEY_A   = 8'hAA;
  localparam logic [BYTE_W-1:0] CODE_KEY_B   = 8'h55;
  localparam logic [BYTE_W-1:0] CODE_IDENT   = 8'h90;
  localparam logic [BYTE_W-1:0] CODE_PROG    = 8'hA0;
  localparam logic [BYTE_W-1:0] CODE_BYPASS  = 8'h20;
  localparam logic [BYTE_W-1:0] CODE_ERSETUP = 8'h80;
  localparam logic [BYTE_W-1:0] CODE_ERCHIP  = 8'h10;
  localparam logic [BYTE_W-1:0] CODE_RESET   = 8'hF0;
  localparam logic [BYTE_W-1:0] CODE_EXIT    = 8'h00;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_IDENT  = 2'd1,
    RD_BYPASS = 2'd2
  } readSel_e;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_PGM,
    SQ_ER1,
    SQ_ER2,
    SQ_ER3,
    SQ_BP_IDLE,
    SQ_BP_PGM,
    SQ_BP_EXIT
  } seq_e;

  typedef struct packed {
    logic atKeyA;
    logic atKeyB;
    logic dKeyA;
    logic dKeyB;
    logic dIdent;
    logic dProg;
    logic dBypass;
    logic dErSetup;
    logic dErChip;
    logic dReset;
    logic dExit;
  } match_t;

  typedef struct packed {
    logic capTarget;
    logic firePgm;
    logic fireErase;
    logic fireReset;
  } strobe_t;
endpackage

// File: rtl/fcd_dpath.sv
module fcd_dpath
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  strobe_t           strb,
  output match_t            match,
  output logic              progStart,
  output logic              eraseStart,
  output logic              resetReq,
  output logic [ADDR_W-1:0] progAddr,
  output logic [BYTE_W-1:0] progData
);
  logic [CMP_W-1:0] cmpAddr;

  // only the low address bits take part in matching
  generate
    if (ADDR_W >= CMP_W) begin : g_cut
      assign cmpAddr = wrAddr[CMP_W-1:0];
    end else begin : g_pad
      assign cmpAddr = CMP_W'(wrAddr);
    end
  endgenerate

  always_comb begin
    match.atKeyA   = (cmpAddr == KEY_ADDR_A);
    match.atKeyB   = (cmpAddr == KEY_ADDR_B);
    match.dKeyA    = (wrData == CODE_KEY_A);
    match.dKeyB    = (wrData == CODE_KEY_B);
    match.dIdent   = (wrData == CODE_IDENT);
    match.dProg    = (wrData == CODE_PROG);
    match.dBypass  = (wrData == CODE_BYPASS);
    match.dErSetup = (wrData == CODE_ERSETUP);
    match.dErChip  = (wrData == CODE_ERCHIP);
    match.dReset   = (wrData == CODE_RESET);
    match.dExit    = (wrData == CODE_EXIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progStart  <= 1'b0;
      eraseStart <= 1'b0;
      resetReq   <= 1'b0;
    end else begin
      progStart  <= strb.firePgm;
      eraseStart <= strb.fireErase;
      resetReq   <= strb.fireReset;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progAddr <= '0;
      progData <= '0;
    end else if (strb.capTarget) begin
      progAddr <= wrAddr;
      progData <= wrData;
    end
  end
endmodule

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import flash_cmd_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     wrValid,
  input  logic     busy,
  input  logic     opError,
  input  match_t   match,
  output strobe_t  strb,
  output readSel_e mode
);
  seq_e     seq, seqNext;
  readSel_e modeNext;
  logic     take;

  assign take = wrValid && !busy;

  always_comb begin
    seqNext  = seq;
    modeNext = mode;
    strb     = '0;
    if (take) begin
      if (mode == RD_BYPASS) begin
        case (seq)
          SQ_BP_PGM: begin
            strb.capTarget = 1'b1;
            strb.firePgm   = 1'b1;
            seqNext        = SQ_BP_IDLE;
          end
          SQ_BP_EXIT: begin
            if (match.dExit) begin
              modeNext = RD_ARRAY;
              seqNext  = SQ_IDLE;
            end else begin
              seqNext = SQ_BP_IDLE;
            end
          end
          default: begin
            seqNext = SQ_BP_IDLE;
            if (match.dProg) seqNext = SQ_BP_PGM;
            else if (match.dIdent) seqNext = SQ_BP_EXIT;
            else if (match.dReset && opError) strb.fireReset = 1'b1;
          end
        endcase
      end else if (seq == SQ_PGM) begin
        strb.capTarget = 1'b1;
        strb.firePgm   = 1'b1;
        seqNext        = SQ_IDLE;
        modeNext       = RD_ARRAY;
      end else if (match.dReset) begin
        strb.fireReset = 1'b1;
        seqNext        = SQ_IDLE;
        modeNext       = RD_ARRAY;
      end else begin
        // default: a write that breaks the sequence
        seqNext  = SQ_IDLE;
        modeNext = RD_ARRAY;
        case (seq)
          SQ_IDLE: if (match.atKeyA && match.dKeyA) begin
            seqNext = SQ_KEY1; modeNext = mode;
          end
          SQ_KEY1: if (match.atKeyB && match.dKeyB) begin
            seqNext = SQ_KEY2; modeNext = mode;
          end
          SQ_KEY2: if (match.atKeyA) begin
            if (match.dIdent) begin
              modeNext = RD_IDENT;
            end else if (match.dProg) begin
              seqNext = SQ_PGM; modeNext = mode;
            end else if (match.dBypass) begin
              seqNext = SQ_BP_IDLE; modeNext = RD_BYPASS;
            end else if (match.dErSetup) begin
              seqNext = SQ_ER1; modeNext = mode;
            end
          end
          SQ_ER1: if (match.atKeyA && match.dKeyA) begin
            seqNext = SQ_ER2; modeNext = mode;
          end
          SQ_ER2: if (match.atKeyB && match.dKeyB) begin
            seqNext = SQ_ER3; modeNext = mode;
          end
          SQ_ER3: if (match.atKeyA && match.dErChip) begin
            strb.fireErase = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seq  <= SQ_IDLE;
      mode <= RD_ARRAY;
    end else begin
      seq  <= seqNext;
      mode <= modeNext;
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              busy,
  input  logic              opError,
  output logic [1:0]        readSel,
  output logic              progStart,
  output logic              eraseStart,
  output logic              resetReq,
  output logic [ADDR_W-1:0] progAddr,
  output logic [7:0]        progData
);
  match_t   match;
  strobe_t  strb;
  readSel_e mode;

  fcd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrValid (wrValid),
    .busy    (busy),
    .opError (opError),
    .match   (match),
    .strb    (strb),
    .mode    (mode)
  );

  fcd_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .strb       (strb),
    .match      (match),
    .progStart  (progStart),
    .eraseStart (eraseStart),
    .resetReq   (resetReq),
    .progAddr   (progAddr),
    .progData   (progData)
  );

  assign readSel = mode;
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [7:0]        wrData,
  input logic              busy,
  input logic [1:0]        readSel,
  input logic              progStart,
  input logic              eraseStart,
  input logic              resetReq,
  input logic [ADDR_W-1:0] progAddr,
  input logic [7:0]        progData
);
  // R3
  pgm_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    progStart |=> !progStart);

  // R3
  pgm_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> (progAddr == $past(wrAddr)) && (progData == $past(wrData)));

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && busy) |=> (!progStart && !eraseStart && !resetReq && $stable(readSel)));

  // R7
  erase_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> (readSel == 2'd0));

  // R1
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progStart, eraseStart, resetReq}));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |=> $stable(readSel));

  // R12
  bypass_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resetReq && ($past(readSel) == 2'd2)) |-> (readSel == 2'd2));
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrValid    (wrValid),
  .wrAddr     (wrAddr),
  .wrData     (wrData),
  .busy       (busy),
  .readSel    (readSel),
  .progStart  (progStart),
  .eraseStart (eraseStart),
  .resetReq   (resetReq),
  .progAddr   (progAddr),
  .progData   (progData)
);

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;
  localparam int ADDR_W = 19;
  localparam int K_PGM = 0, K_ERASE = 1, K_RESET = 2;

  typedef struct {
    int              kind;
    logic [ADDR_W-1:0] addr;
    logic [7:0]      data;
    string           tag;
  } item_t;

  logic clk = 1'b0, rstN = 1'b0, wrValid = 1'b0, busy = 1'b0, opError = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] readSel;
  logic progStart, eraseStart, resetReq;
  logic [ADDR_W-1:0] progAddr;
  logic [7:0] progData;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  item_t expQ[$];

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(ADDR_W)) u_flash_cmd_decoder (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .busy(busy), .opError(opError), .readSel(readSel), .progStart(progStart),
    .eraseStart(eraseStart), .resetReq(resetReq), .progAddr(progAddr), .progData(progData)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic expect_ev(int kind, logic [ADDR_W-1:0] a, logic [7:0] d, string tag);
    item_t it;
    it.kind = kind; it.addr = a; it.data = d; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    wrAddr = a; wrData = d; wrValid = 1'b1;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic unlock(logic [ADDR_W-1:0] hi);
    wr(hi | 19'h00555, 8'hAA);
    wr(hi | 19'h002AA, 8'h55);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: every pulse must match the head of the expected queue
  always @(negedge clk) begin
    if (rstN && (progStart || eraseStart || resetReq)) begin
      int kind;
      kind = progStart ? K_PGM : (eraseStart ? K_ERASE : K_RESET);
      if (expQ.size() == 0) begin
        check(1'b0, "R6/R9/R11", "unexpected pulse kind", kind, -1);
      end else begin
        item_t it;
        it = expQ.pop_front();
        check(kind == it.kind, it.tag, "pulse kind", kind, it.kind);
        if (it.kind == K_PGM) begin
          check(progAddr == it.addr, it.tag, "progAddr", int'(progAddr), int'(it.addr));
          check(progData == it.data, it.tag, "progData", int'(progData), int'(it.data));
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(readSel == 2'd0, "R1", "readSel after reset", readSel, 0);
    check(!progStart && !eraseStart && !resetReq, "R1", "pulses after reset",
          {progStart, eraseStart, resetReq}, 0);

    // R2 identifier mode entry and persistence
    unlock('0); wr(19'h00555, 8'h90);
    check(readSel == 2'd1, "R2", "readSel ident", readSel, 1);
    idle(5);
    check(readSel == 2'd1, "R2", "readSel ident held", readSel, 1);

    // R6 broken sequence drops to array
    wr(19'h00555, 8'hAA); wr(19'h002AB, 8'h55);
    check(readSel == 2'd0, "R6", "readSel after broken seq", readSel, 0);
    wr(19'h00554, 8'hAA);
    check(readSel == 2'd0, "R6", "readSel after wrong addr", readSel, 0);

    // R3 normal program
    unlock('0); wr(19'h00555, 8'hA0);
    expect_ev(K_PGM, 19'h12345, 8'h5A, "R3");
    wr(19'h12345, 8'h5A);
    check(readSel == 2'd0, "R3", "readSel after program", readSel, 0);

    // R4 upper address bits ignored
    unlock(19'h7F000); wr(19'h3D555, 8'h90);
    check(readSel == 2'd1, "R4", "readSel ident with high bits", readSel, 1);

    // R5 single-write reset from ident
    expect_ev(K_RESET, '0, '0, "R5");
    wr(19'h01234, 8'hF0);
    check(readSel == 2'd0, "R5", "readSel after reset cmd", readSel, 0);

    // R7 chip erase, nothing after five writes
    unlock('0); wr(19'h00555, 8'h80); unlock('0);
    check(expQ.size() == 0 && readSel == 2'd0, "R7", "no early erase", expQ.size(), 0);
    expect_ev(K_ERASE, '0, '0, "R7");
    wr(19'h00555, 8'h10);
    check(readSel == 2'd0, "R7", "readSel after erase", readSel, 0);

    // R11 writes while busy ignored
    busy = 1'b1;
    unlock('0); wr(19'h00555, 8'hA0); wr(19'h00042, 8'h11);
    unlock('0); wr(19'h00555, 8'h90); wr(19'h00000, 8'hF0);
    check(readSel == 2'd0, "R11", "readSel while busy", readSel, 0);
    busy = 1'b0;
    wr(19'h002AA, 8'h55);
    check(readSel == 2'd0, "R11", "progress not kept", readSel, 0);

    // R8 bypass entry and two-write program
    unlock('0); wr(19'h00555, 8'h20);
    check(readSel == 2'd2, "R8", "readSel bypass", readSel, 2);
    wr(19'h00000, 8'hA0);
    expect_ev(K_PGM, 19'h4ABCD, 8'hC3, "R8");
    wr(19'h4ABCD, 8'hC3);
    check(readSel == 2'd2, "R8", "readSel stays bypass", readSel, 2);

    // R9 rejected commands in bypass
    wr(19'h00555, 8'h80); wr(19'h00555, 8'h10); wr(19'h00000, 8'hF0);
    wr(19'h00555, 8'hAA); wr(19'h002AA, 8'h55);
    wr(19'h00100, 8'h90); wr(19'h00101, 8'h11);
    check(readSel == 2'd2, "R9", "readSel after rejects", readSel, 2);

    // R12 reset with error keeps bypass
    opError = 1'b1;
    expect_ev(K_RESET, '0, '0, "R12");
    wr(19'h00555, 8'hF0);
    opError = 1'b0;
    check(readSel == 2'd2, "R12", "readSel after error reset", readSel, 2);

    // R10 bypass exit
    wr(19'h7FFFF, 8'h90); wr(19'h00012, 8'h00);
    check(readSel == 2'd0, "R10", "readSel after exit", readSel, 0);
    wr(19'h00000, 8'hA0);
    check(readSel == 2'd0, "R10", "A0 alone in array mode", readSel, 0);

    unlock('0); wr(19'h00555, 8'hA0);
    expect_ev(K_PGM, 19'h00777, 8'h3C, "R3");
    wr(19'h00777, 8'h3C);

    idle(3);
    check(expQ.size() == 0, "R3", "expected pulses left", expQ.size(), 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule